// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit sits beside the FIFOs and line logic of a high-speed UART and turns their event signals into one interrupt request. Six kinds of event are tracked in a status word: a transmit request, a receive trigger, a receive timeout, a framing error, a line break and a receive overrun. The three error kinds and the transmit request are sticky. Software clears them by writing ones. The two receive requests are not sticky: they mirror the receive FIFO's own state, one clock late.

A control word holds the transmit request threshold, three class enables (transmit, receive, error) and a bit that forces a break onto the transmit line. The interrupt output is a registered OR of every pending status bit whose class is enabled. Software accesses both words through a simple select/strobe register port. Status reads and writes use selector value 0, and control uses selector value 1.

Top module: `uart_irq_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the status word and control word read zero, and the interrupt and break outputs are low.
- R2: A pulse on the framing (status bit 3), break (bit 4) or overrun (bit 5) event input sets that bit at the next clock edge. The bit then stays set until software clears it.
- R3: Writing the status word clears each of bits 0, 3, 4 and 5 where the written data holds a 1. Zeros leave those bits unchanged, and written values in bits 1 and 2 have no effect.
- R4: If an event and a clearing write reach the same bit in the same cycle, the bit is set after that edge.
- R5: Status bit 1 (receive trigger) and bit 2 (receive timeout) equal their input levels from the previous cycle.
- R6: Status bit 0 (transmit request) is set in the cycle after the condition "transmit FIFO level at or below threshold" becomes true. The threshold comes from control bits 1:0: code 0 gives 0, code 1 gives 4, code 2 gives 8 and code 3 gives 16 entries.
- R7: Writing a 1 to status bit 6 sets status bit 0, and this takes priority over a clear of bit 0 in the same write. Bit 6 always reads 0.
- R8: Control bits 1:0, 5, 6, 7 and 8 are written by a control write and read back. All other control bits read 0, and the control word holds its value when no control write occurs.
- R9: The interrupt output is high in the cycle after any of these holds: bit 0 is pending with control bit 5 set; bit 1 or 2 is pending with control bit 6 set; or bit 3, 4 or 5 is pending with control bit 7 set. Otherwise it is low.
- R10: The break output equals control bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_ctrl_i | input | 1 | Write target: 0 status, 1 control |
| wr_data_i | input | DATA_W | Write data |
| rd_ctrl_i | input | 1 | Read select: 0 status, 1 control |
| rd_data_o | output | DATA_W | Read data, combinational from the selected register |
| tx_level_i | input | LVL_W | Current transmit FIFO fill level |
| rx_trig_i | input | 1 | Receive FIFO above its trigger level |
| rx_tmo_i | input | 1 | Receive inactivity timeout condition |
| fe_evt_i | input | 1 | Framing error event pulse |
| brk_evt_i | input | 1 | Line break received event pulse |
| ovr_evt_i | input | 1 | Receive overrun event pulse |
| irq_o | output | 1 | Registered interrupt request |
| tx_break_o | output | 1 | Force transmit line to break |

## Verification
The embedded assertions check on every cycle that sticky error bits hold without a clear and set after an event even under a clear. They also check that receive bits track their inputs one cycle later, that a software set reaches bit 0, and that the control word holds without writes. A further check is that the interrupt follows the enabled pending set one cycle later. Only the bench's scenarios show the threshold decoding for each code, the edge-only nature of the transmit request, and the read-back masking of control bits. They also show that clearing with zeros or touching bits 1 and 2 changes nothing. The bench's model compares all outputs with predicted values on every clock.

// File: rtl/uart_irq_pkg.sv
// Package: shared bit positions and helpers for the UART interrupt unit.
// Assumes a 7-bit status layout and a 9-bit meaningful control field.
package uart_irq_pkg;

    localparam int ST_W      = 7;
    localparam int ST_TXREQ  = 0;
    localparam int ST_RXTRIG = 1;
    localparam int ST_RXTMO  = 2;
    localparam int ST_FE     = 3;
    localparam int ST_BRK    = 4;
    localparam int ST_OVR    = 5;
    localparam int ST_TXSET  = 6;

    localparam int CT_W      = 9;
    localparam int CT_TXLVL  = 0;   // two bits, 1:0
    localparam int CT_TXEN   = 5;
    localparam int CT_RXEN   = 6;
    localparam int CT_ERREN  = 7;
    localparam int CT_BREAK  = 8;

    localparam logic [CT_W-1:0] CT_MASK = 9'h1E3;

    // Translate the 2-bit threshold code into an entry count.
    function automatic int unsigned tx_thr_entries(input logic [1:0] code);
        return (code == 2'd0) ? 0 : (4 << (code - 2'd1));
    endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
// Control word register: holds threshold code, class enables and break force.
// Assumes writes are single-cycle strobes; unmapped bits are never stored.
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CT_W-1:0]   ctrl_o,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic              en_tx_o,
    output logic              en_rx_o,
    output logic              en_err_o,
    output logic              brk_o
);

    logic [CT_W-1:0] ctrl_q;

    // Store the mapped control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_i)
            ctrl_q <= data_i[CT_W-1:0] & CT_MASK;
    end

    // Decode threshold code into an entry count of FIFO width.
    always_comb begin
        tx_thr_o = LVL_W'(tx_thr_entries(ctrl_q[CT_TXLVL +: 2]));
    end

    assign ctrl_o   = ctrl_q;
    assign en_tx_o  = ctrl_q[CT_TXEN];
    assign en_rx_o  = ctrl_q[CT_RXEN];
    assign en_err_o = ctrl_q[CT_ERREN];
    assign brk_o    = ctrl_q[CT_BREAK];

    assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(ctrl_q));

endmodule

// File: rtl/uart_irq_status.sv
// Status word: sticky error bits, edge-set transmit request, mirrored
// receive levels. Assumes clr_i is a one-cycle write-ones mask and that
// error inputs are single-cycle pulses from the receive logic.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ST_W-1:0]  clr_i,
    input  logic [LVL_W-1:0] tx_thr_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic             rx_trig_i,
    input  logic             rx_tmo_i,
    input  logic             fe_evt_i,
    input  logic             brk_evt_i,
    input  logic             ovr_evt_i,
    output logic [ST_W-1:0]  status_o
);

    localparam int N_ERR = 3;

    logic [N_ERR-1:0] err_evt;
    logic [N_ERR-1:0] err_q;
    logic             tx_cond, tx_cond_q, tx_req_q;
    logic             rxtrig_q, rxtmo_q;

    assign err_evt = {ovr_evt_i, brk_evt_i, fe_evt_i};

    // One sticky bit per error class; event has priority over clear.
    for (genvar g = 0; g < N_ERR; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)
                err_q[g] <= 1'b0;
            else if (err_evt[g])
                err_q[g] <= 1'b1;
            else if (clr_i[ST_FE+g])
                err_q[g] <= 1'b0;
        end
    end

    assign tx_cond = (tx_level_i <= tx_thr_i);

    // Remember the threshold condition to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_cond_q <= 1'b0;
        else
            tx_cond_q <= tx_cond;
    end

    // Transmit request: set on new condition or software set, else clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_req_q <= 1'b0;
        else if ((tx_cond && !tx_cond_q) || clr_i[ST_TXSET])
            tx_req_q <= 1'b1;
        else if (clr_i[ST_TXREQ])
            tx_req_q <= 1'b0;
    end

    // Receive requests follow FIFO state with one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxtrig_q <= 1'b0;
            rxtmo_q  <= 1'b0;
        end else begin
            rxtrig_q <= rx_trig_i;
            rxtmo_q  <= rx_tmo_i;
        end
    end

    assign status_o = {1'b0, err_q, rxtmo_q, rxtrig_q, tx_req_q};

    assert_err_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_FE] && !clr_i[ST_FE]) |=> status_o[ST_FE]);
    assert_evt_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt_i && clr_i[ST_OVR]) |=> status_o[ST_OVR]);
    assert_rx_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo_i |=> status_o[ST_RXTMO]);
    assert_swset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i[ST_TXSET] |=> status_o[ST_TXREQ]);

endmodule

// File: rtl/uart_irq_combine.sv
// Interrupt combiner: ORs the enabled, pending classes into a registered
// request line. Assumes status and enables are already registered.
module uart_irq_combine
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] status_i,
    input  logic            en_tx_i,
    input  logic            en_rx_i,
    input  logic            en_err_i,
    output logic            irq_o
);

    logic pend_tx, pend_rx, pend_err, any_pend;

    assign pend_tx  = en_tx_i  & status_i[ST_TXREQ];
    assign pend_rx  = en_rx_i  & (status_i[ST_RXTRIG] | status_i[ST_RXTMO]);
    assign pend_err = en_err_i & (|status_i[ST_OVR:ST_FE]);
    assign any_pend = pend_tx | pend_rx | pend_err;

    // Register the request so the line cannot glitch.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= any_pend;
    end

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_tx_i && !en_rx_i && !en_err_i) |=> !irq_o);
    assert_irq_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_err_i && status_i[ST_BRK]) |=> irq_o);

endmodule

// File: rtl/uart_irq_unit.sv
// Top of the UART interrupt unit: register port decode, read mux and the
// three sub-blocks. Assumes a synchronous register bus with one-cycle strobes.
module uart_irq_unit
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_ctrl_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_ctrl_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic              rx_trig_i,
    input  logic              rx_tmo_i,
    input  logic              fe_evt_i,
    input  logic              brk_evt_i,
    input  logic              ovr_evt_i,
    output logic              irq_o,
    output logic              tx_break_o
);

    logic [ST_W-1:0]  status;
    logic [ST_W-1:0]  clr_mask;
    logic [CT_W-1:0]  ctrl;
    logic [LVL_W-1:0] tx_thr;
    logic             en_tx, en_rx, en_err;
    logic             ctrl_wr;

    assign ctrl_wr  = wr_en_i & wr_ctrl_i;
    assign clr_mask = (wr_en_i && !wr_ctrl_i) ? wr_data_i[ST_W-1:0] : '0;

    uart_irq_ctrl #(.DATA_W(DATA_W), .LVL_W(LVL_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr), .data_i(wr_data_i),
        .ctrl_o(ctrl), .tx_thr_o(tx_thr), .en_tx_o(en_tx), .en_rx_o(en_rx),
        .en_err_o(en_err), .brk_o(tx_break_o)
    );

    uart_irq_status #(.LVL_W(LVL_W)) status_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_mask), .tx_thr_i(tx_thr),
        .tx_level_i(tx_level_i), .rx_trig_i(rx_trig_i), .rx_tmo_i(rx_tmo_i),
        .fe_evt_i(fe_evt_i), .brk_evt_i(brk_evt_i), .ovr_evt_i(ovr_evt_i),
        .status_o(status)
    );

    uart_irq_combine combine_i (
        .clk(clk), .rst_n(rst_n), .status_i(status), .en_tx_i(en_tx),
        .en_rx_i(en_rx), .en_err_i(en_err), .irq_o(irq_o)
    );

    // Read mux: selected register, zero-extended.
    always_comb begin
        rd_data_o = '0;
        if (rd_ctrl_i)
            rd_data_o[CT_W-1:0] = ctrl;
        else
            rd_data_o[ST_W-1:0] = status;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && ctrl == '0 && !irq_o));

endmodule

// File: tb/uart_irq_unit_tb_top.sv
module uart_irq_unit_tb_top;

    localparam int DATA_W = 32;
    localparam int LVL_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, wr_ctrl = 1'b0, rd_ctrl = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic [LVL_W-1:0]  tx_level = 7'd20;
    logic              rx_trig = 1'b0, rx_tmo = 1'b0;
    logic              fe = 1'b0, brk = 1'b0, ovr = 1'b0;
    logic              irq, tx_brk;

    int checks = 0, failures = 0;
    string cur_req = "R1";

    // Behavioural reference state
    bit [6:0] m_st;
    bit [8:0] m_ct;
    bit       m_irq, m_prev;

    always #5 clk = ~clk;

    uart_irq_unit #(.DATA_W(DATA_W), .LVL_W(LVL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_ctrl_i(wr_ctrl),
        .wr_data_i(wr_data), .rd_ctrl_i(rd_ctrl), .rd_data_o(rd_data),
        .tx_level_i(tx_level), .rx_trig_i(rx_trig), .rx_tmo_i(rx_tmo),
        .fe_evt_i(fe), .brk_evt_i(brk), .ovr_evt_i(ovr),
        .irq_o(irq), .tx_break_o(tx_brk)
    );

    task automatic model_edge();
        int thr;
        bit cond, pend;
        bit [6:0] clr;
        if (!rst_n) begin
            m_st = '0; m_ct = '0; m_irq = 0; m_prev = 0;
            return;
        end
        pend = (m_ct[5] && m_st[0]) || (m_ct[6] && (m_st[1] || m_st[2])) ||
               (m_ct[7] && (m_st[3] || m_st[4] || m_st[5]));
        case (m_ct[1:0])
            2'd0: thr = 0;
            2'd1: thr = 4;
            2'd2: thr = 8;
            default: thr = 16;
        endcase
        cond = (int'(tx_level) <= thr);
        clr  = (wr_en && !wr_ctrl) ? wr_data[6:0] : 7'd0;
        if ((cond && !m_prev) || clr[6]) m_st[0] = 1;
        else if (clr[0]) m_st[0] = 0;
        m_st[1] = rx_trig;
        m_st[2] = rx_tmo;
        if (fe) m_st[3] = 1; else if (clr[3]) m_st[3] = 0;
        if (brk) m_st[4] = 1; else if (clr[4]) m_st[4] = 0;
        if (ovr) m_st[5] = 1; else if (clr[5]) m_st[5] = 0;
        m_st[6] = 0;
        if (wr_en && wr_ctrl) m_ct = wr_data[8:0] & 9'h1E3;
        m_prev = cond;
        m_irq = pend;
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    // One clock: model update at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rd_ctrl = 1'b0; #1;
        check("status", rd_data, {25'd0, m_st});
        rd_ctrl = 1'b1; #1;
        check("ctrl", rd_data, {23'd0, m_ct});
        check("irq", {31'd0, irq}, {31'd0, m_irq});
        check("break", {31'd0, tx_brk}, {31'd0, m_ct[8]});
    endtask

    task automatic wr(bit to_ctrl, logic [31:0] d);
        wr_en = 1'b1; wr_ctrl = to_ctrl; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R8 control write masking, R10 break output
        cur_req = "R8";
        wr(1, 32'hFFFF_FFFF);
        idle(1);
        cur_req = "R10";
        wr(1, 32'h0000_0100);
        idle(1);
        cur_req = "R8";
        wr(1, 32'h0000_0000);

        // R2 sticky errors
        cur_req = "R2";
        fe = 1; step(); fe = 0; idle(3);
        brk = 1; step(); brk = 0;
        ovr = 1; step(); ovr = 0; idle(2);

        // R3 clear by ones only; bits 1,2 unaffected
        cur_req = "R3";
        wr(0, 32'h0000_0000);
        rx_trig = 1; idle(1);
        wr(0, 32'h0000_0006);
        wr(0, 32'h0000_0008);
        wr(0, 32'h0000_0030);
        rx_trig = 0; idle(1);

        // R4 event beats clear
        cur_req = "R4";
        fe = 1; wr(0, 32'h0000_0008); fe = 0;
        ovr = 1; wr(0, 32'h0000_0038); ovr = 0;
        idle(1);
        wr(0, 32'h0000_0038);

        // R5 receive levels follow inputs
        cur_req = "R5";
        rx_trig = 1; idle(2); rx_tmo = 1; idle(1);
        rx_trig = 0; idle(1); rx_tmo = 0; idle(2);

        // R6 threshold codes and edge-only set
        cur_req = "R6";
        wr(1, 32'h0000_0002);
        tx_level = 7'd9; idle(1);
        tx_level = 7'd8; idle(2);
        wr(0, 32'h0000_0001);
        tx_level = 7'd5; idle(2);
        tx_level = 7'd20;
        wr(1, 32'h0000_0003);
        tx_level = 7'd17; idle(1);
        tx_level = 7'd16; idle(1);
        wr(0, 32'h0000_0001);
        wr(1, 32'h0000_0001);
        tx_level = 7'd5; idle(1);
        tx_level = 7'd4; idle(1);
        wr(0, 32'h0000_0001);
        wr(1, 32'h0000_0000);
        tx_level = 7'd1; idle(1);
        tx_level = 7'd0; idle(1);
        wr(0, 32'h0000_0001);
        tx_level = 7'd20; idle(1);

        // R7 software set of transmit request
        cur_req = "R7";
        wr(0, 32'h0000_0040);
        idle(1);
        wr(0, 32'h0000_0041);
        wr(0, 32'h0000_0001);

        // R9 class enables
        cur_req = "R9";
        wr(0, 32'h0000_0040);
        wr(1, 32'h0000_0020); idle(2);
        wr(1, 32'h0000_00C0); idle(2);
        rx_tmo = 1; idle(2); rx_tmo = 0; idle(2);
        brk = 1; step(); brk = 0; idle(2);
        wr(1, 32'h0000_0040); idle(2);
        wr(0, 32'h0000_0011); idle(2);
        wr(1, 32'h0000_00E0);
        fe = 1; step(); fe = 0;
        wr(0, 32'h0000_0008); idle(2);

        // R1 re-entry into reset
        cur_req = "R1";
        ovr = 1; rst_n = 1'b0; step(); ovr = 0; idle(1);
        rst_n = 1'b1; idle(1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule